// File: doc/BRIEF.md
# Serial-Bus Parallel Port Expander Slave

This block is a register-less two-wire serial bus slave that connects the bus straight to one 8-bit parallel port. SCL and SDA are oversampled on the system clock. Each line passes through a two-flop synchronizer and a persistence filter. The filtered lines feed a detector for start, repeated start and stop conditions.

The slave answers to one 7-bit address. The upper four bits are fixed at `0100` (parameter `ADDR_BASE`) and the lower three bits come from strap inputs. The straps are captured at every start condition. A write carries one data byte, which is latched onto the port outputs during its acknowledge clock. A read returns snapshots of the port pins, one byte after another, for as long as the master acknowledges.

There is no sub-address and no internal register file. The SDA output is an open-drain enable: `sda_oe` high means the pad pulls SDA low. Two strobes, one for writes and one for reads, mark the acknowledge clock that latched or sampled the port, so that neighbouring interrupt logic can use them.

Top module: `ioexp_i2c_expander`

## Requirements
- R1: While `rst_n` is low and after its release, `port_out` is 8'hFF, `sda_oe` is 0 and both strobes are 0.
- R2: After a start, the first byte is received MSB first as seven address bits followed by R/W (1 = read). The slave acknowledges by holding `sda_oe` high through the SCL high phase of the ninth clock only if the address equals `{4'b0100, strap}`.
- R3: Any other address, including the all-zero general call byte 8'h00, is not acknowledged and leaves `port_out` unchanged.
- R4: In a write, the acknowledged data byte appears on `port_out` at the SCL rising edge of its acknowledge clock, together with a one-cycle `wr_strobe`.
- R5: Bytes that follow the first data byte of a write are neither acknowledged nor latched.
- R6: A stop received part-way through a data byte discards that byte, and `port_out` keeps the last acknowledged value.
- R7: In a read, each byte sent is the `pins_in` value sampled at the SCL rising edge of the previous acknowledge clock (the address acknowledge or the master acknowledge), MSB first. Each sample raises a one-cycle `rd_strobe`.
- R8: The slave keeps sending bytes while the master acknowledges. After a master NACK it releases SDA (`sda_oe` = 0) until the next start.
- R9: The strap value is captured at the start condition, so a strap change after the start does not affect matching of that transfer.
- R10: A repeated start in place of a stop begins a new address phase.
- R11: A pulse on SCL shorter than `FILT_CNT` system clocks is ignored.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL pad level |
| sda_in | input | 1 | Sampled SDA pad level |
| strap | input | STRAP_W | Low address bits, captured at start |
| pins_in | input | 8 | Port pin levels for reads |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| port_out | output | 8 | Latched port output value |
| wr_strobe | output | 1 | One-cycle pulse when the port is written |
| rd_strobe | output | 1 | One-cycle pulse when the pins are sampled for a read |

## Verification
A wrong bus state or a miscounted bit shows at the ports within one byte time. Either the acknowledge lands on the wrong clock, or `port_out` takes a value shifted by one bit, or a read returns a shifted or stale byte. A strap or filter fault shows as a missing or extra acknowledge on the address byte. A stop or NACK that is not honoured shows as `sda_oe` still held after the transfer ends. A snapshot taken on the wrong edge shows when the pins change between the master acknowledge and the next byte.

// File: rtl/ioexp_pkg.sv
// Shared types for the serial-bus port expander.
// Assumes a byte-wide bus protocol and a single parallel port.
package ioexp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring bus until next start
        ST_ADDR,   // shifting address byte
        ST_AACK,   // acknowledging address
        ST_WDATA,  // shifting write data
        ST_WACK,   // acknowledging write data, latching port
        ST_RDATA,  // shifting read data out
        ST_RACK    // sampling master acknowledge
    } bus_st_t;
endpackage

// File: rtl/ioexp_line_filter.sv
// Synchronizes one bus line and filters glitches.
// Assumes the line idles high; a level must persist FILT_CNT clocks to pass.
module ioexp_line_filter #(
    parameter int FILT_CNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CNT + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // two-flop synchronizer into the system clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], raw};
    end

    // accept a new level only after FILT_CNT consecutive samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            cnt_q <= '0;
        end else if (sync_q[1] != clean) begin
            if (cnt_q == CW'(FILT_CNT - 1)) begin
                clean <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/ioexp_bus_cond.sv
// Filters SCL and SDA and decodes clock edges, start and stop conditions.
// Assumes both lines see identical filter delay so their order is preserved.
module ioexp_bus_cond #(
    parameter int FILT_CNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [1:0] raw_v;
    logic [1:0] clean_v;
    logic       scl_q, sda_q;

    assign raw_v = {sda_raw, scl_raw};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            ioexp_line_filter #(.FILT_CNT(FILT_CNT)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .raw   (raw_v[g]),
                .clean (clean_v[g])
            );
        end
    endgenerate

    assign scl_f = clean_v[0];
    assign sda_f = clean_v[1];

    // previous filtered levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/ioexp_slave_fsm.sv
// Bus protocol engine: address match, write latch, read snapshot.
// Assumes clean single-cycle edge and condition pulses from ioexp_bus_cond.
module ioexp_slave_fsm
    import ioexp_pkg::*;
#(
    parameter int         STRAP_W   = 3,
    parameter logic [6:0] ADDR_BASE = 7'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_f,
    input  logic               start_c,
    input  logic               stop_c,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  pins_in,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  port_out,
    output logic               wr_strobe,
    output logic               rd_strobe
);
    localparam int HI_W = 7 - STRAP_W;

    bus_st_t             st_q;
    logic [3:0]          bitcnt_q;
    logic [BYTE_W-1:0]   shreg_q;
    logic                rw_q, mack_q;
    logic [STRAP_W-1:0]  strap_q;
    logic                addr_hit;

    // compare received address with fixed bits and captured straps
    always_comb begin
        addr_hit = (shreg_q[7 -: HI_W] == ADDR_BASE[6 -: HI_W]) &&
                   (shreg_q[STRAP_W:1] == strap_q);
    end

    // protocol sequencing, shifting, port latch and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            strap_q   <= '0;
            port_out  <= '1;
            wr_strobe <= 1'b0;
            rd_strobe <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            rd_strobe <= 1'b0;
            if (start_c) begin
                st_q     <= ST_ADDR;
                bitcnt_q <= '0;
                strap_q  <= strap;
            end else if (stop_c) begin
                st_q <= ST_IDLE;
            end else begin
                case (st_q)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg_q  <= {shreg_q[6:0], sda_f};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            bitcnt_q <= '0;
                            if (st_q == ST_WDATA) begin
                                st_q <= ST_WACK;
                            end else if (addr_hit) begin
                                st_q <= ST_AACK;
                                rw_q <= shreg_q[0];
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_rise && rw_q) begin
                            shreg_q   <= pins_in;
                            rd_strobe <= 1'b1;
                        end else if (scl_fall) begin
                            st_q <= rw_q ? ST_RDATA : ST_WDATA;
                        end
                    end
                    ST_WACK: begin
                        if (scl_rise) begin
                            port_out  <= shreg_q;
                            wr_strobe <= 1'b1;
                        end else if (scl_fall) begin
                            st_q <= ST_IDLE;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            shreg_q  <= {shreg_q[6:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 4'd1;
                            if (bitcnt_q == 4'd7) begin
                                st_q     <= ST_RACK;
                                bitcnt_q <= '0;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_f;
                            if (!sda_f) begin
                                shreg_q   <= pins_in;
                                rd_strobe <= 1'b1;
                            end
                        end else if (scl_fall) begin
                            st_q <= mack_q ? ST_RDATA : ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // open-drain drive: acknowledges and read data bits
    always_comb begin
        case (st_q)
            ST_AACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA:         sda_oe = ~shreg_q[7];
            default:          sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/ioexp_i2c_expander.sv
// Top: serial-bus slave bridging to one 8-bit parallel port.
// Assumes clk is fast enough that each SCL phase spans well over FILT_CNT+4 clocks.
module ioexp_i2c_expander #(
    parameter int         FILT_CNT  = 3,
    parameter int         STRAP_W   = 3,
    parameter logic [6:0] ADDR_BASE = 7'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    input  logic [7:0]         pins_in,
    output logic               sda_oe,
    output logic [7:0]         port_out,
    output logic               wr_strobe,
    output logic               rd_strobe
);
    logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;

    ioexp_bus_cond #(.FILT_CNT(FILT_CNT)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    ioexp_slave_fsm #(.STRAP_W(STRAP_W), .ADDR_BASE(ADDR_BASE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_f     (sda_f),
        .start_c   (start_c),
        .stop_c    (stop_c),
        .strap     (strap),
        .pins_in   (pins_in),
        .sda_oe    (sda_oe),
        .port_out  (port_out),
        .wr_strobe (wr_strobe),
        .rd_strobe (rd_strobe)
    );
endmodule

// File: rtl/ioexp_chk.sv
// Property checker for the port expander, bound to the top module.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module ioexp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       stop_c,
    input logic       sda_oe,
    input logic       wr_strobe,
    input logic       rd_strobe,
    input logic [7:0] port_out
);
    // R12
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);
    // R12
    oe_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_f);
    // R4
    port_change_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_out) |-> wr_strobe);
    // R4
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);
    // R7
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && rd_strobe));
    // R8
    stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !sda_oe);
endmodule

bind ioexp_i2c_expander ioexp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .stop_c    (stop_c),
    .sda_oe    (sda_oe),
    .wr_strobe (wr_strobe),
    .rd_strobe (rd_strobe),
    .port_out  (port_out)
);

// File: tb/tb_ioexp_i2c_expander.sv
module tb_ioexp_i2c_expander;
    localparam int Q    = 10;
    localparam int HALF = 20;
    localparam int FILT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, glitch = 1'b0;
    logic [2:0] strap = 3'd0;
    logic [7:0] pins = 8'h00;
    logic       sda_oe, wr_strobe, rd_strobe;
    logic [7:0] port_out;
    wire        scl_line = scl_m | glitch;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0, oe_viol = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;

    always #10 clk = ~clk;

    ioexp_i2c_expander #(.FILT_CNT(FILT)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .strap(strap), .pins_in(pins), .sda_oe(sda_oe), .port_out(port_out),
        .wr_strobe(wr_strobe), .rd_strobe(rd_strobe)
    );

    always @(posedge clk) if (rst_n) begin
        if (wr_strobe) wr_cnt++;
        if (rd_strobe) rd_cnt++;
    end

    // R12 monitor: open-drain enable must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && scl_m) oe_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] own_addr(input logic [2:0] s, input bit rd);
        return {4'b0100, s, rd};
    endfunction

    task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; wclk(Q); scl_m = 1'b1; wclk(HALF); scl_m = 1'b0; wclk(Q);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        b = sda_line; wclk(Q); scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
        put_bit(!mack);
    endtask

    initial begin
        bit ack, ack2;
        logic [7:0] rd, expect_port;
        int w0, r0;
        void'($urandom(32'd2024));

        wclk(3);
        // R1 during reset
        chk(port_out == 8'hFF && !sda_oe && !wr_strobe && !rd_strobe, "R1 in reset",
            {sda_oe, port_out}, 32'h0FF);
        rst_n = 1'b1;
        wclk(5);
        chk(port_out == 8'hFF && !sda_oe && !wr_strobe && !rd_strobe, "R1 after reset",
            {sda_oe, port_out}, 32'h0FF);

        // R2 R4 basic write
        strap = 3'd3; w0 = wr_cnt;
        bus_start(); send_byte(own_addr(3'd3, 0), ack);
        chk(ack, "R2 address ack", ack, 1);
        send_byte(8'hA5, ack2);
        chk(ack2, "R4 data ack", ack2, 1);
        chk(port_out == 8'hA5, "R4 port latched at ack", port_out, 8'hA5);
        chk(wr_cnt == w0 + 1, "R4 one write strobe", wr_cnt - w0, 1);
        bus_stop();

        // R3 general call and foreign address
        bus_start(); send_byte(8'h00, ack);
        chk(!ack, "R3 general call not acked", ack, 0);
        send_byte(8'h12, ack2); bus_stop();
        chk(port_out == 8'hA5, "R3 port unchanged", port_out, 8'hA5);
        bus_start(); send_byte(own_addr(3'd4, 0), ack); bus_stop();
        chk(!ack, "R3 strap mismatch not acked", ack, 0);

        // R5 extra write bytes ignored
        bus_start(); send_byte(own_addr(3'd3, 0), ack); send_byte(8'h5A, ack);
        send_byte(8'h3C, ack2); bus_stop();
        chk(!ack2, "R5 second byte not acked", ack2, 0);
        chk(port_out == 8'h5A, "R5 port keeps first byte", port_out, 8'h5A);

        // R6 stop inside a data byte
        bus_start(); send_byte(own_addr(3'd3, 0), ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        chk(port_out == 8'h5A, "R6 partial byte discarded", port_out, 8'h5A);

        // R7 R8 multi-byte read with snapshot timing
        pins = 8'hC3; r0 = rd_cnt;
        bus_start(); send_byte(own_addr(3'd3, 1), ack);
        chk(ack, "R7 read address ack", ack, 1);
        pins = 8'h81;
        recv_byte(rd, 1'b1);
        chk(rd == 8'hC3, "R7 first byte is address-ack snapshot", rd, 8'hC3);
        pins = 8'h7E;
        recv_byte(rd, 1'b0);
        chk(rd == 8'h81, "R7 second byte is master-ack snapshot", rd, 8'h81);
        chk(rd_cnt == r0 + 2, "R7 read strobes", rd_cnt - r0, 2);
        wclk(8);
        chk(!sda_oe, "R8 released after NACK", sda_oe, 0);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        chk(!sda_oe, "R8 stays released until start", sda_oe, 0);
        bus_stop();

        // R9 strap captured at start
        strap = 3'd2;
        bus_start(); strap = 3'd5;
        send_byte(own_addr(3'd2, 0), ack);
        chk(ack, "R9 captured strap matches", ack, 1);
        send_byte(8'h44, ack2); bus_stop();
        chk(port_out == 8'h44, "R9 write with captured strap", port_out, 8'h44);

        // R10 repeated start: write then read
        strap = 3'd6; pins = 8'h9D;
        bus_start(); send_byte(own_addr(3'd6, 0), ack); send_byte(8'h11, ack2);
        bus_start(); send_byte(own_addr(3'd6, 1), ack);
        chk(ack, "R10 address after repeated start", ack, 1);
        recv_byte(rd, 1'b0); bus_stop();
        chk(rd == 8'h9D, "R10 read after repeated start", rd, 8'h9D);
        chk(port_out == 8'h11, "R10 write before repeated start", port_out, 8'h11);

        // R11 short SCL glitch rejected
        bus_start(); send_byte(own_addr(3'd6, 0), ack);
        glitch = 1'b1; wclk(FILT - 1); glitch = 1'b0; wclk(Q);
        send_byte(8'h96, ack2); bus_stop();
        chk(ack2, "R11 byte acked despite glitch", ack2, 1);
        chk(port_out == 8'h96, "R11 glitch not counted as clock", port_out, 8'h96);

        // random mix
        expect_port = port_out;
        for (int it = 0; it < 40; it++) begin
            logic [6:0] a7;
            logic [7:0] d;
            bit rdir, exp_ack;
            strap = 3'($urandom);
            a7 = ($urandom % 2) ? {4'b0100, strap} : 7'($urandom);
            exp_ack = (a7 == {4'b0100, strap});
            rdir = 1'($urandom);
            d = 8'($urandom);
            if (rdir) pins = d;
            bus_start(); send_byte({a7, rdir}, ack);
            chk(ack == exp_ack, exp_ack ? "R2 random ack" : "R3 random no-ack", ack, exp_ack);
            if (ack && !rdir) begin
                send_byte(d, ack2); expect_port = d;
            end else if (ack && rdir) begin
                recv_byte(rd, 1'b0);
                chk(rd == d, "R7 random read", rd, d);
            end
            bus_stop();
            chk(port_out == expect_port, "R4 random port", port_out, expect_port);
            chk(!sda_oe, "R8 random released", sda_oe, 0);
        end

        chk(oe_viol == 0, "R12 sda_oe moved while SCL high", oe_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule